// File: doc/BRIEF.md
# DMA Page Table Address Translator

This block turns a 32-bit logical DMA address into a physical address by looking up a single-level page table that lives in system memory. A requester hands over a logical address through a valid/ready handshake. The block splits the address into a page number and a 12-bit offset. It checks the page number against a programmable table size and works out where the matching entry sits in memory. For an in-range page it reads the entry's frame word over a simple read master port, then returns the frame combined with the untouched offset.

The table size register counts bytes, not entries. Each entry occupies eight bytes: a frame word at the lower address, then a companion word that translation never reads. The most significant bit of the table base register plays no part in forming the entry address. A page beyond the table, or a read that comes back with an error, yields a response with the permit bit low and an address of zero. Nothing is cached: every request causes a fresh table read, and only one lookup is in flight at any time.

Top module: `pgx_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and `mem_req` are 0.
- R2: On a permitted response, `rsp_paddr[11:0]` equals bits [11:0] of the logical address.
- R3: On a permitted response, `rsp_paddr[31:12]` equals bits [31:12] of the frame word returned by memory; frame bits [11:0] have no effect.
- R4: The entry read address is `(tbl_base & 32'h7FFF_FFFF) + (laddr >> 12) * 8`, modulo 2^32; bit 31 of `tbl_base` has no effect.
- R5: A page index is in range only when `(laddr >> 12) < (tbl_limit / 8)` with integer division. An out-of-range request raises no `mem_req` and returns `rsp_permit` = 0 with `rsp_paddr` = 0.
- R6: A table read completed with `mem_err` = 1 returns `rsp_permit` = 0 and `rsp_paddr` = 0.
- R7: Only one lookup is outstanding. `req_ready` stays 0 from acceptance until the response is taken, and `rsp_valid`, `rsp_permit` and `rsp_paddr` hold steady while `rsp_ready` is 0.
- R8: Translations are not cached: repeating a request for the same page performs the table read again.
- R9: While `mem_req` is 1 and `mem_ack` is 0, `mem_req` stays 1 and `mem_addr` stays unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_base | input | 32 | Table base byte address (bit 31 ignored) |
| tbl_limit | input | 32 | Table size in bytes |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_laddr | input | 32 | Logical address to translate |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_permit | output | 1 | 1 = translated, 0 = fault |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| mem_req | output | 1 | Table read request, held until acknowledged |
| mem_addr | output | 32 | Byte address of the frame word |
| mem_ack | input | 1 | Read completes this cycle |
| mem_rdata | input | 32 | Frame word, valid with `mem_ack` |
| mem_err | input | 1 | Read failed, valid with `mem_ack` |

## Verification
A corrupted captured offset or entry address shows up at the ports within one cycle of acceptance: `mem_addr` carries the wrong byte address as soon as `mem_req` rises, or the response offset differs on the cycle `rsp_valid` rises. A wrong range decision shows in the cycle after acceptance, either as a read that should not happen or as a fault response with no read at all. A sequencing error appears as `req_ready` returning early, a response that changes while stalled, or a missing read on a repeated page, each visible one cycle after the event that caused it.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

   typedef enum logic [1:0] {
      PGX_IDLE  = 2'd0,
      PGX_FETCH = 2'd1,
      PGX_RESP  = 2'd2
   } pgx_state_e;

endpackage

// File: rtl/pgx_index_calc.sv
module pgx_index_calc #(
   parameter int ADDR_W      = 32,
   parameter int PAGE_SHIFT  = 12,
   parameter int ENTRY_SHIFT = 3,
   parameter int BASE_KEEP_W = 31
) (
   input  logic [ADDR_W-1:0] laddr,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] limit,
   output logic              in_range,
   output logic [ADDR_W-1:0] entry_addr
);

   localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};

   logic [ADDR_W-1:0] page_idx;
   logic [ADDR_W-1:0] entry_cnt;
   logic [ADDR_W-1:0] base_eff;

   initial begin
      assert (PAGE_SHIFT > 0 && PAGE_SHIFT < ADDR_W)
         else $error("pgx_index_calc: PAGE_SHIFT out of range");
      assert (ENTRY_SHIFT < PAGE_SHIFT)
         else $error("pgx_index_calc: ENTRY_SHIFT must be below PAGE_SHIFT");
      assert (BASE_KEEP_W > 0 && BASE_KEEP_W <= ADDR_W)
         else $error("pgx_index_calc: BASE_KEEP_W out of range");
   end

   generate
      if (BASE_KEEP_W >= ADDR_W) begin : g_base_full
         assign base_eff = base;
      end else begin : g_base_masked
         localparam logic [ADDR_W-1:0] BASE_MASK = ALL_ONES >> (ADDR_W - BASE_KEEP_W);
         assign base_eff = base & BASE_MASK;
      end
   endgenerate

   assign page_idx   = laddr >> PAGE_SHIFT;
   assign entry_cnt  = limit >> ENTRY_SHIFT;
   assign in_range   = page_idx < entry_cnt;
   assign entry_addr = base_eff + (page_idx << ENTRY_SHIFT);

endmodule

// File: rtl/pgx_walk_fsm.sv
module pgx_walk_fsm
   import pgx_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int PAGE_SHIFT = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_laddr,
   input  logic              idx_in_range,
   input  logic [ADDR_W-1:0] idx_entry_addr,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic              rsp_permit,
   output logic [ADDR_W-1:0] rsp_paddr,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [ADDR_W-1:0] mem_rdata,
   input  logic              mem_err
);

   pgx_state_e             state_q;
   logic [PAGE_SHIFT-1:0]  offset_q;
   logic [ADDR_W-1:0]      maddr_q;
   logic                   permit_q;
   logic [ADDR_W-1:0]      paddr_q;
   logic                   frame_low_unused;

   assign frame_low_unused = ^mem_rdata[PAGE_SHIFT-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= PGX_IDLE;
         offset_q <= '0;
         maddr_q  <= '0;
         permit_q <= 1'b0;
         paddr_q  <= '0;
      end else begin
         unique case (state_q)
            PGX_IDLE: begin
               if (req_valid) begin
                  offset_q <= req_laddr[PAGE_SHIFT-1:0];
                  maddr_q  <= idx_entry_addr;
                  if (idx_in_range) begin
                     state_q <= PGX_FETCH;
                  end else begin
                     permit_q <= 1'b0;
                     paddr_q  <= '0;
                     state_q  <= PGX_RESP;
                  end
               end
            end
            PGX_FETCH: begin
               if (mem_ack) begin
                  permit_q <= !mem_err;
                  paddr_q  <= mem_err ? '0 : {mem_rdata[ADDR_W-1:PAGE_SHIFT], offset_q};
                  state_q  <= PGX_RESP;
               end
            end
            PGX_RESP: begin
               if (rsp_ready) state_q <= PGX_IDLE;
            end
            default: state_q <= PGX_IDLE;
         endcase
      end
   end

   assign req_ready  = (state_q == PGX_IDLE);
   assign mem_req    = (state_q == PGX_FETCH);
   assign mem_addr   = maddr_q;
   assign rsp_valid  = (state_q == PGX_RESP);
   assign rsp_permit = permit_q;
   assign rsp_paddr  = paddr_q;

   // R7: a stalled response does not change
   assert_rsp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_permit) && $stable(rsp_paddr));

   // R7: acceptance closes the request side
   assert_single_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);

   // R6: faults carry a zero address
   assert_fault_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_permit |-> rsp_paddr == '0);

   // R6: an error completion turns into a fault
   assert_err_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ack && mem_err |=> rsp_valid && !rsp_permit);

   // R3: the frame bits of a good read reach the response
   assert_frame_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ack && !mem_err |=>
         rsp_valid && rsp_permit &&
         rsp_paddr[ADDR_W-1:PAGE_SHIFT] == $past(mem_rdata[ADDR_W-1:PAGE_SHIFT]));

   // R9: an unacknowledged read stays put
   assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

endmodule

// File: rtl/pgx_xlate.sv
module pgx_xlate #(
   parameter int ADDR_W      = 32,
   parameter int PAGE_SHIFT  = 12,
   parameter int ENTRY_SHIFT = 3,
   parameter int BASE_KEEP_W = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] tbl_base,
   input  logic [ADDR_W-1:0] tbl_limit,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_laddr,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic              rsp_permit,
   output logic [ADDR_W-1:0] rsp_paddr,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [ADDR_W-1:0] mem_rdata,
   input  logic              mem_err
);

   logic              idx_in_range;
   logic [ADDR_W-1:0] idx_entry_addr;

   pgx_index_calc #(
      .ADDR_W      (ADDR_W),
      .PAGE_SHIFT  (PAGE_SHIFT),
      .ENTRY_SHIFT (ENTRY_SHIFT),
      .BASE_KEEP_W (BASE_KEEP_W)
   ) i_index_calc (
      .laddr      (req_laddr),
      .base       (tbl_base),
      .limit      (tbl_limit),
      .in_range   (idx_in_range),
      .entry_addr (idx_entry_addr)
   );

   pgx_walk_fsm #(
      .ADDR_W     (ADDR_W),
      .PAGE_SHIFT (PAGE_SHIFT)
   ) i_walk_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .req_ready      (req_ready),
      .req_laddr      (req_laddr),
      .idx_in_range   (idx_in_range),
      .idx_entry_addr (idx_entry_addr),
      .rsp_valid      (rsp_valid),
      .rsp_ready      (rsp_ready),
      .rsp_permit     (rsp_permit),
      .rsp_paddr      (rsp_paddr),
      .mem_req        (mem_req),
      .mem_addr       (mem_addr),
      .mem_ack        (mem_ack),
      .mem_rdata      (mem_rdata),
      .mem_err        (mem_err)
   );

   // R5: an out-of-range page never starts a table read
   assert_no_fetch_oor_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && !idx_in_range |=> !mem_req && rsp_valid && !rsp_permit);

endmodule

// File: tb/test_pgx_xlate.sv
module test_pgx_xlate;

   typedef struct packed {
      logic [31:0] laddr;
      logic [31:0] base;
      logic [31:0] limit;
      logic [31:0] frame;
      logic        err;
      logic [1:0]  lat;
      logic        fetch;
      logic        permit;
      logic [31:0] maddr;
      logic [31:0] paddr;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t TBL [NV] = '{
      // in range, plain offset and frame
      '{32'h0000_3ABC, 32'h0010_0000, 32'h0000_0100, 32'h1234_5FFF, 1'b0, 2'd1, 1'b1, 1'b1, 32'h0010_0018, 32'h1234_5ABC},
      // base bit 31 set
      '{32'h0001_0004, 32'h8020_0000, 32'h0000_0100, 32'hABCD_E000, 1'b0, 2'd0, 1'b1, 1'b1, 32'h0020_0080, 32'hABCD_E004},
      // last in-range index
      '{32'h0001_F123, 32'h0000_1000, 32'h0000_0100, 32'h0000_7001, 1'b0, 2'd2, 1'b1, 1'b1, 32'h0000_10F8, 32'h0000_7123},
      // first out-of-range index
      '{32'h0002_0000, 32'h0000_1000, 32'h0000_0100, 32'h0000_0000, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000},
      // byte limit 15 -> one entry, index 0
      '{32'h0000_0FFF, 32'h0000_2000, 32'h0000_000F, 32'hFFFF_F000, 1'b0, 2'd3, 1'b1, 1'b1, 32'h0000_2000, 32'hFFFF_FFFF},
      // byte limit 15, index 1
      '{32'h0000_1000, 32'h0000_2000, 32'h0000_000F, 32'h0000_0000, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000},
      // read error
      '{32'h0000_5000, 32'h0000_3000, 32'h0000_0100, 32'h7777_7000, 1'b1, 2'd1, 1'b1, 1'b0, 32'h0000_3028, 32'h0000_0000},
      // empty table
      '{32'h0000_0000, 32'h0000_3000, 32'h0000_0000, 32'h0000_0000, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000},
      // top page of the 4 GiB space
      '{32'hFFFF_F010, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0ABC_D000, 1'b0, 2'd2, 1'b1, 1'b1, 32'h007F_FFF8, 32'h0ABC_D010},
      // masked base plus index crosses bit 31
      '{32'h0000_1008, 32'hFFFF_FFF8, 32'h0000_0100, 32'h5555_5000, 1'b0, 2'd1, 1'b1, 1'b1, 32'h8000_0000, 32'h5555_5008}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] tbl_base = '0;
   logic [31:0] tbl_limit = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_laddr = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic        rsp_permit;
   logic [31:0] rsp_paddr;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        mem_err = 1'b0;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   pgx_xlate i_pgx_xlate (
      .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base), .tbl_limit(tbl_limit),
      .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_permit(rsp_permit),
      .rsp_paddr(rsp_paddr), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // One transaction; returns the number of table reads seen.
   task automatic run_vec(input vec_t v, input string tag, output int fetches);
      logic [31:0] held_addr;
      fetches = 0;
      @(negedge clk);
      chk(req_ready, {"R7 idle ready ", tag}, {31'd0, req_ready}, 32'd1);
      tbl_base  = v.base;
      tbl_limit = v.limit;
      req_laddr = v.laddr;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready, {"R7 busy after accept ", tag}, {31'd0, req_ready}, 32'd0);
      for (int cyc = 0; cyc < 30 && !rsp_valid; cyc++) begin
         if (mem_req) begin
            fetches++;
            chk(mem_addr == v.maddr, {"R4 entry address ", tag}, mem_addr, v.maddr);
            held_addr = mem_addr;
            for (int w = 0; w < int'(v.lat); w++) begin
               @(negedge clk);
               chk(mem_req && mem_addr == held_addr, {"R9 read held ", tag}, mem_addr, held_addr);
            end
            mem_ack   = 1'b1;
            mem_rdata = v.frame;
            mem_err   = v.err;
            @(negedge clk);
            mem_ack   = 1'b0;
            mem_err   = 1'b0;
            mem_rdata = '0;
         end else begin
            @(negedge clk);
         end
      end
      chk(rsp_valid, {"R7 response present ", tag}, {31'd0, rsp_valid}, 32'd1);
      chk(fetches == (v.fetch ? 1 : 0), {"R5 read count ", tag}, fetches, {31'd0, v.fetch});
      chk(rsp_permit == v.permit, {"R5/R6 permit ", tag}, {31'd0, rsp_permit}, {31'd0, v.permit});
      chk(rsp_paddr == v.paddr, {"R2/R3 paddr ", tag}, rsp_paddr, v.paddr);
      // stall two cycles
      repeat (2) @(negedge clk);
      chk(rsp_valid && rsp_paddr == v.paddr && rsp_permit == v.permit && !req_ready,
          {"R7 stall hold ", tag}, rsp_paddr, v.paddr);
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk(!rsp_valid && req_ready, {"R7 release ", tag}, {30'd0, rsp_valid, req_ready}, 32'd1);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      int f;
      int f2;
      vec_t rep;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(req_ready && !rsp_valid && !mem_req, "R1 reset outputs",
          {29'd0, req_ready, rsp_valid, mem_req}, 32'd4);

      for (int i = 0; i < NV; i++) begin
         run_vec(TBL[i], $sformatf("vec%0d", i), f);
      end

      // R8: the same page twice, each must read the table
      rep = TBL[0];
      run_vec(rep, "R8 first", f);
      rep.frame = 32'h0BAD_0000;
      rep.paddr = 32'h0BAD_0ABC;
      run_vec(rep, "R8 second", f2);
      chk(f == 1 && f2 == 1, "R8 repeated page reads again", f + f2, 32'd2);

      // R4: only bit 31 of base differs, same entry address
      rep = TBL[0];
      rep.base = 32'h8010_0000;
      run_vec(rep, "R4 base31", f);

      // R1: reset during an outstanding read returns to idle
      @(negedge clk);
      tbl_base = 32'h0; tbl_limit = 32'h100; req_laddr = 32'h0; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk(req_ready && !rsp_valid && !mem_req, "R1 reset mid-read",
          {29'd0, req_ready, rsp_valid, mem_req}, 32'd4);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule